// File: doc/BRIEF.md
# Interrupt Pin Waveform Generator

This block turns an internal interrupt condition into the waveform seen on an external interrupt pin. A 2-bit mode input picks one of four behaviours. In the two level modes the pin follows a pending level, either inverted (active low) or as is (active high). In the two pulse modes the pin stays at its idle level and gives a short low-going or high-going pulse each time a strobe reports that a new interrupt has been raised.

A second input chooses how the pin is driven. In push-pull drive the output enable is held on. In open-drain drive the pin is driven only while its value is low and is released while it is high, so that an external pull-up can share the line with other drivers. The mode input is registered, so a new mode takes effect on the next clock. Changing the mode cancels any pulse that is running.

Top module: `irq_pin_driver`

## Requirements
- R1: While reset is held and right after it, `pin_out` is 1, no pulse is running, and the registered mode is 2'b00.
- R2: Mode 2'b00 (level, active low): one clock after `pend` is sampled, `pin_out` equals the inverse of `pend`. `new_irq` has no effect.
- R3: Mode 2'b01 (level, active high): one clock after `pend` is sampled, `pin_out` equals `pend`. `new_irq` has no effect.
- R4: Mode 2'b10 (low-going pulse): `pin_out` idles at 1. When `new_irq` is sampled high, `pin_out` is 0 for exactly PULSE_LEN (default 4) cycles, starting on the next cycle. `pend` has no effect.
- R5: Mode 2'b11 (high-going pulse): `pin_out` idles at 0. When `new_irq` is sampled high, `pin_out` is 1 for exactly PULSE_LEN cycles, starting on the next cycle. `pend` has no effect.
- R6: A `new_irq` sampled while a pulse is running restarts the pulse count, so the pulse ends PULSE_LEN cycles after the last strobe.
- R7: A new value on `mode` governs `pin_out` from the next clock on. The clock edge that takes the new mode cancels any running pulse, and a `new_irq` sampled on that same edge is ignored.
- R8: With `od_en` = 0 (push-pull), `pin_oe` is 1 at all times.
- R9: With `od_en` = 1 (open-drain), `pin_oe` is 1 exactly when `pin_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | Signalling mode: 00 level low, 01 level high, 10 low pulse, 11 high pulse |
| pend | input | 1 | Interrupt pending level |
| new_irq | input | 1 | One-cycle strobe that marks a newly raised interrupt |
| od_en | input | 1 | 1 selects open-drain drive, 0 selects push-pull |
| pin_out | output | 1 | Value for the interrupt pin |
| pin_oe | output | 1 | Output enable for the interrupt pin |

## Verification
The hardest case to reach is a mode change that lands while a pulse is partly done, with a strobe on the same edge. There the cancel and the reload compete for the counter. The stimulus starts a pulse, waits a chosen number of cycles, then changes the mode and strobes together. Some of these changes keep the pulse polarity family (10 to 11), and some move to a level mode and back. A randomised phase also drives strobes back to back and sometimes changes the mode, so that retriggers and cancellations fall on every count value. The reference model is compared with the outputs on every cycle.

// File: rtl/irq_pin_pkg.sv
package irq_pin_pkg;

   typedef enum logic [1:0] {
      IRQ_LVL_LO   = 2'b00,
      IRQ_LVL_HI   = 2'b01,
      IRQ_PULSE_LO = 2'b10,
      IRQ_PULSE_HI = 2'b11
   } irq_mode_e;

   function automatic logic is_pulse_mode(input irq_mode_e m);
      return m[1];
   endfunction

   function automatic logic idle_level(input irq_mode_e m);
      return ~m[0];
   endfunction

endpackage

// File: rtl/irq_pulse_timer.sv
module irq_pulse_timer #(
   parameter int PULSE_LEN = 4,
   localparam int CNT_W = $clog2(PULSE_LEN + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic load,
   output logic active
);

   localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(PULSE_LEN);

   initial begin
      if (PULSE_LEN < 1) $error("PULSE_LEN must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (clr)              cnt_q <= '0;
      else if (load)             cnt_q <= LOAD_VAL;
      else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
   end

   assign active = (cnt_q != '0);

   // R6: a strobe always restarts the full count
   p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !clr) |=> (cnt_q == LOAD_VAL));

   // R7: a clear leaves no pulse running
   p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !active);

endmodule

// File: rtl/irq_wave_sel.sv
module irq_wave_sel
   import irq_pin_pkg::*;
(
   input  irq_mode_e mode_q,
   input  logic      lvl_q,
   input  logic      pulse_act,
   output logic      pin_val
);

   always_comb begin
      unique case (mode_q)
         IRQ_LVL_LO:   pin_val = ~lvl_q;
         IRQ_LVL_HI:   pin_val = lvl_q;
         IRQ_PULSE_LO: pin_val = ~pulse_act;
         IRQ_PULSE_HI: pin_val = pulse_act;
         default:      pin_val = 1'b1;
      endcase
   end

endmodule

// File: rtl/irq_pad_drive.sv
module irq_pad_drive #(
   parameter bit OD_SUPPORT = 1'b1
) (
   input  logic pin_val,
   input  logic od_en,
   output logic pin_out,
   output logic pin_oe
);

   assign pin_out = pin_val;

   generate
      if (OD_SUPPORT) begin : g_od
         assign pin_oe = od_en ? ~pin_val : 1'b1;
      end else begin : g_pp
         logic unused_od;
         assign unused_od = od_en;
         assign pin_oe    = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/irq_pin_driver.sv
module irq_pin_driver
   import irq_pin_pkg::*;
#(
   parameter int PULSE_LEN  = 4,
   parameter bit OD_SUPPORT = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] mode,
   input  logic       pend,
   input  logic       new_irq,
   input  logic       od_en,
   output logic       pin_out,
   output logic       pin_oe
);

   irq_mode_e mode_in, mode_q;
   logic      lvl_q;
   logic      mode_chg;
   logic      pulse_load;
   logic      pulse_act;
   logic      pin_val;

   assign mode_in    = irq_mode_e'(mode);
   assign mode_chg   = (mode_in != mode_q);
   assign pulse_load = new_irq && is_pulse_mode(mode_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= IRQ_LVL_LO;
         lvl_q  <= 1'b0;
      end else begin
         mode_q <= mode_in;
         lvl_q  <= pend;
      end
   end

   irq_pulse_timer #(.PULSE_LEN(PULSE_LEN)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (mode_chg),
      .load   (pulse_load),
      .active (pulse_act)
   );

   irq_wave_sel u_sel (
      .mode_q    (mode_q),
      .lvl_q     (lvl_q),
      .pulse_act (pulse_act),
      .pin_val   (pin_val)
   );

   irq_pad_drive #(.OD_SUPPORT(OD_SUPPORT)) u_pad (
      .pin_val (pin_val),
      .od_en   (od_en),
      .pin_out (pin_out),
      .pin_oe  (pin_oe)
   );

   // R2: active-low level follows the inverted pending input
   p_lvl_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b00 && mode_q == IRQ_LVL_LO) |=> (pin_out == !$past(pend)));

   // R3: active-high level follows the pending input
   p_lvl_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b01 && mode_q == IRQ_LVL_HI) |=> (pin_out == $past(pend)));

   // R4: a strobe in low-pulse mode pulls the pin low on the next cycle
   p_low_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b10 && mode_q == IRQ_PULSE_LO && new_irq) |=> !pin_out);

   // R5: a strobe in high-pulse mode drives the pin high on the next cycle
   p_high_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b11 && mode_q == IRQ_PULSE_HI && new_irq) |=> pin_out);

   // R7: a mode change yields the new mode's idle level in pulse modes
   p_mode_cancel_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_chg && mode[1]) |=> (pin_out == !$past(mode[0])));

   // R9: an open-drain pin is never driven high
   p_od_no_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (od_en && pin_out) |-> !pin_oe);

endmodule

// File: tb/sim_irq_pin_driver.sv
`timescale 1ns/1ps
module sim_irq_pin_driver;

   localparam int LEN = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] mode = 2'b00;
   logic       pend = 1'b0;
   logic       new_irq = 1'b0;
   logic       od_en = 1'b0;
   logic       pin_out, pin_oe;

   int n_checks = 0;
   int n_fail   = 0;
   string tag = "R1";

   always #2 clk = ~clk;

   irq_pin_driver #(.PULSE_LEN(LEN), .OD_SUPPORT(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .mode(mode), .pend(pend),
      .new_irq(new_irq), .od_en(od_en), .pin_out(pin_out), .pin_oe(pin_oe)
   );

   // behavioural reference
   int m_mode = 0;
   int m_lvl  = 0;
   int m_left = 0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_mode = 0; m_lvl = 0; m_left = 0;
      end else begin
         if (int'(mode) != m_mode)            m_left = 0;
         else if (new_irq && m_mode >= 2)     m_left = LEN;
         else if (m_left > 0)                 m_left = m_left - 1;
         m_mode = int'(mode);
         m_lvl  = int'(pend);
      end
   end

   function automatic logic exp_pin();
      case (m_mode)
         0: return logic'(m_lvl == 0);
         1: return logic'(m_lvl != 0);
         2: return logic'(m_left == 0);
         default: return logic'(m_left != 0);
      endcase
   endfunction

   task automatic check(input string req, input logic act, input logic exp, input string what);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
      end
   endtask

   // compare on every cycle, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         check(tag, pin_out, exp_pin(), "pin_out");
         if (od_en) check("R9", pin_oe, ~exp_pin(), "pin_oe");
         else       check("R8", pin_oe, 1'b1, "pin_oe");
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic strobe();
      new_irq = 1'b1; cyc(1); new_irq = 1'b0;
   endtask

   initial begin
      #400000;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      cyc(3);
      check("R1", pin_out, 1'b1, "reset pin");
      check("R1", pin_oe, 1'b1, "reset oe");
      rst_n = 1'b1;
      cyc(2);
      check("R1", pin_out, 1'b1, "after reset");

      // R2 level low, strobes ignored
      tag = "R2";
      pend = 1; cyc(3); pend = 0; cyc(2); pend = 1; strobe(); cyc(2);
      pend = 0; strobe(); cyc(2);

      // R3 level high
      tag = "R3"; mode = 2'b01;
      cyc(1); pend = 1; cyc(3); strobe(); pend = 0; cyc(3);

      // R4 low pulse, width checked at ports
      tag = "R4"; mode = 2'b10; cyc(2);
      pend = 1; strobe();
      for (int i = 0; i < LEN; i++) begin
         check("R4", pin_out, 1'b0, "pulse low phase"); cyc(1);
      end
      check("R4", pin_out, 1'b1, "pulse end");
      pend = 0; cyc(3);

      // R6 retrigger mid-pulse
      tag = "R6"; strobe(); cyc(2); strobe();
      for (int i = 0; i < LEN; i++) begin
         check("R6", pin_out, 1'b0, "restarted pulse"); cyc(1);
      end
      check("R6", pin_out, 1'b1, "restarted pulse end");

      // R5 high pulse, od enabled
      tag = "R5"; mode = 2'b11; od_en = 1; cyc(2);
      check("R5", pin_out, 1'b0, "idle low");
      strobe(); strobe(); cyc(LEN + 2);

      // R7 mode change mid pulse with same-edge strobe
      tag = "R7";
      strobe(); cyc(1);
      mode = 2'b10; new_irq = 1; cyc(1); new_irq = 0;
      check("R7", pin_out, 1'b1, "cancelled to idle");
      strobe(); cyc(2);
      mode = 2'b00; pend = 1; cyc(1); mode = 2'b10; cyc(1);
      check("R7", pin_out, 1'b1, "no pulse after return");
      od_en = 0;

      // randomised phase, checked by the model each cycle
      tag = "R6";
      for (int i = 0; i < 3000; i++) begin
         new_irq = ($urandom_range(0, 3) == 0);
         pend    = $urandom_range(0, 1);
         od_en   = ($urandom_range(0, 7) == 0) ? ~od_en : od_en;
         if ($urandom_range(0, 19) == 0) mode = 2'($urandom_range(0, 3));
         cyc(1);
      end
      new_irq = 0;
      cyc(LEN + 2);

      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule